// File: doc/BRIEF.md
# Alternate-Boot Watchdog

This block is a memory-mapped watchdog for systems that can boot from one of two flash devices. Software arms it after boot. If software stops restarting it, the block requests a system reset and flips a sticky indicator so that the next boot comes from the other flash. A prescaler divides the system clock into a tick of one tenth of a second. A down-counter decrements once per tick while the watchdog is enabled. The counter takes a new start value only when software writes a fixed restart word.

There are three 32-bit registers on a one-cycle bus. The control register holds the enable and the boot-source indicator. The reload register holds a 13-bit expiry time and also returns the live counter value. The restart register accepts the restart word. Read data is combinational from the current address. Software clears the indicator by writing a separate key value into the control register. When the counter is at zero and the watchdog is enabled, the block pulses its reset request for one cycle, toggles the indicator and drops the enable.

Top module: `altboot_wdog`

## Requirements
- R1: After reset, the control register reads 0, the reload register reads 220 in bits [12:0] and 220 in bits [31:16], and the reset request is low.
- R2: The control register is at 0x64, the reload register at 0x68 and the restart register at 0x6C. The restart register and every unmapped address read as zero.
- R3: A write to the reload register keeps only bits [12:0], so 0xFFFFFFFF reads back as 0x1FFF in bits [12:0]. Such a write does not change the counter.
- R4: A write of exactly 0x00004755 to the restart register loads the counter with the reload value. Any other word written there leaves the counter unchanged. The counter reads back in bits [31:16] of the reload register.
- R5: While enabled, the counter decreases by one every CYC_PER_TICK clock cycles. The first decrement comes CYC_PER_TICK cycles after the write that sets the enable.
- R6: With reload value R, the reset request rises R*CYC_PER_TICK+1 cycles after the enabling write. It stays high for exactly one cycle. R=0 gives a timeout one cycle after enabling.
- R7: An expiry inverts the boot-source bit (bit 4 of control) and clears the enable bit (bit 0 of control).
- R8: A control write with 0xEA in bits [23:16] clears the boot-source bit. A control write with any other value there leaves the boot-source bit unchanged.
- R9: When an expiry and a control write fall in the same cycle, the expiry wins for both control bits. When a restart load and a tick fall in the same cycle, the load wins.
- R10: Writing 0 to the control register disables the watchdog, and the counter then holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| rst_req | output | 1 | One-cycle reset request on expiry |
| boot_alt | output | 1 | Sticky indicator: next boot from the alternate flash |

## Verification
Two pairs of functions can collide. The first pair is an expiry and a software control write in the same cycle. The bench provokes it by arming a zero reload and writing the control register with the clear key and the enable set on the very next edge. It then expects the boot bit to be toggled rather than cleared, and the enable to be low. The second pair is a restart load and a prescaler tick on the same edge. The bench places the restart write exactly on the tick edge, after changing the reload value. It expects the new reload value rather than a decremented count.

// File: rtl/abw_pkg.sv
package abw_pkg;
   localparam int unsigned OFS_CTRL    = 32'h64;
   localparam int unsigned OFS_RELOAD  = 32'h68;
   localparam int unsigned OFS_RESTART = 32'h6C;
   localparam logic [31:0] RESTART_KEY = 32'h0000_4755;
   localparam logic [7:0]  CLEAR_KEY   = 8'hEA;
   localparam int unsigned EN_BIT      = 0;
   localparam int unsigned BOOT_BIT    = 4;
   localparam int unsigned KEY_LSB     = 16;
   localparam int unsigned CNT_LSB     = 16;

   typedef enum logic [1:0] {
      SEL_NONE,
      SEL_CTRL,
      SEL_RELOAD,
      SEL_RESTART
   } abw_sel_e;
endpackage

// File: rtl/abw_prescaler.sv
module abw_prescaler #(
   parameter int unsigned CYC_PER_TICK = 20_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clr,
   output logic tick
);
   generate
      if (CYC_PER_TICK < 1) begin : g_bad
         $error("abw_prescaler: CYC_PER_TICK must be at least 1");
      end
      if (CYC_PER_TICK == 1) begin : g_direct
         assign tick = run && !clr;
      end else begin : g_count
         localparam int unsigned PW = $clog2(CYC_PER_TICK);
         localparam logic [PW-1:0] LAST = PW'(CYC_PER_TICK - 1);
         logic [PW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_q <= '0;
            end else if (!run || clr || div_q == LAST) begin
               div_q <= '0;
            end else begin
               div_q <= div_q + 1'b1;
            end
         end
         assign tick = run && !clr && (div_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/abw_downcount.sv
module abw_downcount #(
   parameter int unsigned W       = 13,
   parameter int unsigned RST_VAL = 220
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic [W-1:0] cnt,
   output logic         zero
);
   generate
      if (RST_VAL >= (1 << W)) begin : g_bad
         $error("abw_downcount: RST_VAL does not fit in W bits");
      end
   endgenerate

   logic [W-1:0] cnt_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= W'(RST_VAL);
      end else if (load) begin
         cnt_q <= load_val;
      end else if (dec && cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end
   assign cnt  = cnt_q;
   assign zero = (cnt_q == '0);
endmodule

// File: rtl/altboot_wdog.sv
module altboot_wdog
   import abw_pkg::*;
#(
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned RELOAD_W     = 13,
   parameter int unsigned CYC_PER_TICK = 20_000_000,
   parameter int unsigned RST_RELOAD   = 220
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              rst_req,
   output logic              boot_alt
);
   generate
      if (ADDR_W < 7) begin : g_bad_addr
         $error("altboot_wdog: ADDR_W too small for the register offsets");
      end
      if (RELOAD_W < 1 || RELOAD_W > 16) begin : g_bad_rw
         $error("altboot_wdog: RELOAD_W must be 1..16");
      end
   endgenerate

   abw_sel_e           sel;
   logic               wr_ctrl, wr_rel, wr_rst;
   logic               en_q, boot_q, rst_req_q;
   logic [RELOAD_W-1:0] reload_q;
   logic [RELOAD_W-1:0] cnt;
   logic               zero, tick, expire;

   always_comb begin
      if (bus_addr == ADDR_W'(OFS_CTRL))         sel = SEL_CTRL;
      else if (bus_addr == ADDR_W'(OFS_RELOAD))  sel = SEL_RELOAD;
      else if (bus_addr == ADDR_W'(OFS_RESTART)) sel = SEL_RESTART;
      else                                       sel = SEL_NONE;
   end

   assign wr_ctrl = bus_we && (sel == SEL_CTRL);
   assign wr_rel  = bus_we && (sel == SEL_RELOAD);
   assign wr_rst  = bus_we && (sel == SEL_RESTART) && (bus_wdata == RESTART_KEY);
   assign expire  = en_q && zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         boot_q    <= 1'b0;
         rst_req_q <= 1'b0;
         reload_q  <= RELOAD_W'(RST_RELOAD);
      end else begin
         rst_req_q <= expire;
         if (expire) begin
            en_q   <= 1'b0;
            boot_q <= ~boot_q;
         end else if (wr_ctrl) begin
            en_q <= bus_wdata[EN_BIT];
            if (bus_wdata[KEY_LSB +: 8] == CLEAR_KEY) boot_q <= 1'b0;
         end
         if (wr_rel) reload_q <= bus_wdata[RELOAD_W-1:0];
      end
   end

   abw_prescaler #(.CYC_PER_TICK(CYC_PER_TICK)) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (en_q),
      .clr  (wr_rst),
      .tick (tick)
   );

   abw_downcount #(.W(RELOAD_W), .RST_VAL(RST_RELOAD)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (wr_rst),
      .load_val(reload_q),
      .dec     (tick),
      .cnt     (cnt),
      .zero    (zero)
   );

   always_comb begin
      bus_rdata = '0;
      unique case (sel)
         SEL_CTRL: begin
            bus_rdata[EN_BIT]   = en_q;
            bus_rdata[BOOT_BIT] = boot_q;
         end
         SEL_RELOAD: begin
            bus_rdata[RELOAD_W-1:0]         = reload_q;
            bus_rdata[CNT_LSB +: RELOAD_W]  = cnt;
         end
         default: bus_rdata = '0;
      endcase
   end

   assign rst_req  = rst_req_q;
   assign boot_alt = boot_q;
endmodule

// File: rtl/altboot_wdog_chk.sv
module altboot_wdog_chk #(
   parameter int unsigned RELOAD_W = 13
) (
   input logic                clk,
   input logic                rst_n,
   input logic                rst_req,
   input logic                boot_alt,
   input logic                en,
   input logic [RELOAD_W-1:0] cnt,
   input logic                tick,
   input logic                load
);
   p_pulse_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   p_boot_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (boot_alt != $past(boot_alt)));

   p_en_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> !en);

   p_hold_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !load) |=> $stable(cnt));

   p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

   p_tick_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> en);
endmodule

bind altboot_wdog altboot_wdog_chk #(.RELOAD_W(RELOAD_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .rst_req (rst_req),
   .boot_alt(boot_alt),
   .en      (en_q),
   .cnt     (cnt),
   .tick    (tick),
   .load    (wr_rst)
);

// File: tb/sim_altboot_wdog.sv
`timescale 1ns/1ps
module sim_altboot_wdog;
   localparam int N = 4;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rst_req, boot_alt;

   int n_run = 0, n_fail = 0, cyc = 0;

   altboot_wdog #(.ADDR_W(8), .RELOAD_W(13), .CYC_PER_TICK(N), .RST_RELOAD(220)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req), .boot_alt(boot_alt)
   );

   always #2.5 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cyc);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run = n_run + 1;
      if (!ok) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic cycles(input int n);
      repeat (n) begin @(posedge clk); @(negedge clk); end
   endtask

   initial begin
      logic [31:0] v;
      logic        exp_boot;
      int          k;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(8'h64, v); chk(v == 32'h0, "R1 ctrl", v, 32'h0);
      rd(8'h68, v); chk(v == ((32'd220 << 16) | 32'd220), "R1 reload", v, (32'd220 << 16) | 32'd220);
      chk(rst_req == 1'b0, "R1 rst_req", {31'b0, rst_req}, 32'h0);

      // R2 map and unmapped reads
      for (int a = 8'h60; a <= 8'h70; a += 4) begin
         if (a != 8'h64 && a != 8'h68) begin
            rd(8'(a), v); chk(v == 32'h0, "R2 zero read", v, 32'h0);
         end
      end
      rd(8'h00, v); chk(v == 32'h0, "R2 addr 0", v, 32'h0);

      // R3 reload width
      wr(8'h68, 32'hFFFF_FFFF);
      rd(8'h68, v); chk(v[15:0] == 16'h1FFF, "R3 reload mask", v, 32'h1FFF);
      chk(v[31:16] == 16'd220, "R3 counter untouched", {16'b0, v[31:16]}, 32'd220);

      // R4 restart key
      wr(8'h6C, 32'h0000_4754);
      rd(8'h68, v); chk(v[31:16] == 16'd220, "R4 wrong key", {16'b0, v[31:16]}, 32'd220);
      wr(8'h6C, 32'h0001_4755);
      rd(8'h68, v); chk(v[31:16] == 16'd220, "R4 upper bits", {16'b0, v[31:16]}, 32'd220);
      wr(8'h6C, 32'h0000_4755);
      rd(8'h68, v); chk(v[31:16] == 16'h1FFF, "R4 load", {16'b0, v[31:16]}, 32'h1FFF);

      // R5 / R10 decrement rate and hold while disabled
      wr(8'h68, 32'd5); wr(8'h6C, 32'h4755);
      wr(8'h64, 32'h1);
      cycles(9);
      rd(8'h68, v); chk(v[31:16] == 16'd3, "R5 rate", {16'b0, v[31:16]}, 32'd3);
      wr(8'h64, 32'h0);
      cycles(20);
      rd(8'h68, v); chk(v[31:16] == 16'd3, "R10 hold", {16'b0, v[31:16]}, 32'd3);
      rd(8'h64, v); chk(v[0] == 1'b0, "R10 disabled", v, 32'h0);

      // R6 / R7 sweep of reload values
      exp_boot = 1'b0;
      for (int r = 0; r <= 6; r++) begin
         wr(8'h68, 32'(r)); wr(8'h6C, 32'h4755);
         rd(8'h68, v); chk(v[31:16] == 16'(r), "R4 readback", {16'b0, v[31:16]}, 32'(r));
         wr(8'h64, 32'h1);
         k = 0;
         do begin cycles(1); k++; end while (!rst_req && k < 200);
         chk(k == r * N + 1, "R6 expiry time", 32'(k), 32'(r * N + 1));
         exp_boot = ~exp_boot;
         rd(8'h64, v);
         chk(v == {27'b0, exp_boot, 4'b0}, "R7 ctrl after expiry", v, {27'b0, exp_boot, 4'b0});
         chk(boot_alt == exp_boot, "R7 boot pin", {31'b0, boot_alt}, {31'b0, exp_boot});
         cycles(1);
         chk(rst_req == 1'b0, "R6 one cycle", {31'b0, rst_req}, 32'h0);
      end

      // R8 clear key (boot is 1 after seven expiries)
      wr(8'h64, 32'h00AB_0000);
      rd(8'h64, v); chk(v[4] == 1'b1, "R8 wrong key keeps", v, 32'h10);
      wr(8'h64, 32'h00EA_0000);
      rd(8'h64, v); chk(v[4] == 1'b0, "R8 clear", v, 32'h0);

      // R9 expiry vs control write in the same cycle
      wr(8'h68, 32'd0); wr(8'h6C, 32'h4755);
      wr(8'h64, 32'h1);
      wr(8'h64, 32'h00EA_0001);
      chk(rst_req == 1'b1, "R9 expiry fired", {31'b0, rst_req}, 32'h1);
      rd(8'h64, v); chk(v == 32'h10, "R9 expiry wins", v, 32'h10);

      // R9 restart vs tick in the same cycle
      wr(8'h64, 32'h00EA_0000);
      wr(8'h68, 32'd3); wr(8'h6C, 32'h4755);
      wr(8'h68, 32'd6);
      wr(8'h64, 32'h1);
      cycles(N - 1);
      wr(8'h6C, 32'h4755);
      rd(8'h68, v); chk(v[31:16] == 16'd6, "R9 load wins", {16'b0, v[31:16]}, 32'd6);
      cycles(N);
      rd(8'h68, v); chk(v[31:16] == 16'd5, "R5 after reload", {16'b0, v[31:16]}, 32'd5);
      wr(8'h64, 32'h0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule